// File: doc/BRIEF.md
# PLL Power and Retune Sequencer

This block drives the digital control bits of one on-chip PLL through its three life-cycle operations: bring-up, shut-down and a change of frequency. A request arrives as a one-cycle pulse. The block then steps the power, isolation, enable, tuner-enable and reset-release outputs in a fixed order. It inserts microsecond waits between the steps that need them, and it times those waits with a single down-counter whose lengths are derived from the clock frequency parameter `CLK_MHZ`, so 1 us equals `CLK_MHZ` cycles.

A retune request captures a new divider word and post-divider code. If the PLL is running, the block raises a frequency-change flag in the top bit of a 32-bit configuration word and holds it for a settle window. If the PLL is off, the words are only loaded. While a sequence runs, `busy` is high and every new request is dropped. A one-cycle `done` pulse marks the end of each sequence. The analog loop, lock detection and any software register file lie outside the block.

Top module: `pll_seq_ctrl`

## Requirements
- R1: After a synchronous active-low reset the outputs are `iso_en`=1, `pwr_on`=0, `pll_en`=0, `tuner_en`=0, `rst_bar`=0, `busy`=0, `done`=0, `prepared`=0, `div_load`=0, and `div_word`, `pdiv_word`, `cfg_word` and `tuner_word` are all zero.
- R2: A prepare request accepted at clock edge E sets `pwr_on` at E. It clears `iso_en` at E+C, where C = `CLK_MHZ` × `PWR_US`. It sets every bit of `pll_en` at E+2C and sets `tuner_en` at E+2C+1.
- R3: `SETTLE_US` × `CLK_MHZ` cycles after `tuner_en` rises, the bring-up ends. `rst_bar` is set at that edge when `HAS_RSTB`=1 and stays 0 when `HAS_RSTB`=0.
- R4: An unprepare request accepted at edge E changes one output per cycle with no waits, in this order: `rst_bar` cleared (only when `HAS_RSTB`=1), `tuner_en` cleared, `pll_en` cleared, `iso_en` set, `pwr_on` cleared. The first step happens at E.
- R5: `prepared` equals bit 0 of `pll_en`.
- R6: A retune request accepted while `pll_en[0]`=1 does four things at edge E. It loads `tune_div` into `div_word` and `tune_pdiv` into `pdiv_word`, pulses `div_load` for one cycle, and sets the change flag `cfg_word[31]`. The flag clears after S = `SETTLE_US` × `CLK_MHZ` cycles, at edge E+S, and the sequence ends at that edge.
- R7: A retune request accepted while `pll_en[0]`=0 loads the words and pulses `div_load`. It leaves `cfg_word[31]` at 0, never raises `busy`, and pulses `done` right after edge E.
- R8: `cfg_word` holds the change flag in bit 31, `div_word` in bits `DIV_W`-1..0, and zeros elsewhere. When `HAS_TUNER`=1, each retune loads `tuner_word` with that retune's `cfg_word` value plus one, modulo 2^32.
- R9: A request that arrives while `busy` is high is ignored. When several requests arrive together in idle, prepare wins over unprepare, and unprepare wins over retune.
- R10: `busy` is high from the accepting edge until the edge that completes the sequence. At that completing edge `busy` falls and `done` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_prep | input | 1 | Prepare (bring-up) request pulse |
| req_unprep | input | 1 | Unprepare (shut-down) request pulse |
| req_tune | input | 1 | Retune request pulse |
| tune_div | input | DIV_W | New feedback divider word |
| tune_pdiv | input | PDIV_W | New post-divider code |
| pwr_on | output | 1 | PLL power switch |
| iso_en | output | 1 | Output isolation |
| pll_en | output | EN_W | Enable bits |
| tuner_en | output | 1 | Tuner enable |
| rst_bar | output | 1 | Reset release |
| div_load | output | 1 | One-cycle divider load strobe |
| div_word | output | DIV_W | Current divider word |
| pdiv_word | output | PDIV_W | Current post-divider code |
| cfg_word | output | 32 | Change flag and divider word |
| tuner_word | output | 32 | Tuner word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished pulse |
| prepared | output | 1 | PLL enabled status |

## Verification
The sequencer is driven with these patterns:
- A retune while the PLL is off and one while it is on. Comparing the two shows whether the change flag and the settle wait are gated on the enable bit.
- A full bring-up followed by a shut-down. This checks step ordering and the exact edge of every wait.
- Requests fired into the middle of a running sequence. These show whether dropped requests leave any trace.
- Coincident request pairs and triples in idle. These pin down the priority order.

A second instance built without the reset-release feature runs the same bring-up, and it shows that the optional step is the only thing that changes.

// File: rtl/pll_seq_pkg.sv
// Package: shared state and request types for the PLL sequencer.
// Assumes a 32-bit configuration word with the change flag in the top bit.
package pll_seq_pkg;

    localparam int CFG_W   = 32;
    localparam int CHG_BIT = 31;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UP_W1,
        ST_UP_W2,
        ST_UP_TUN,
        ST_UP_W3,
        ST_DN_TUN,
        ST_DN_EN,
        ST_DN_ISO,
        ST_DN_PWR,
        ST_RT_W
    } seq_state_e;

    typedef enum logic [1:0] {
        REQ_NONE,
        REQ_UP,
        REQ_DOWN,
        REQ_TUNE
    } req_kind_e;

    // Fixed priority: bring-up, then shut-down, then retune.
    function automatic req_kind_e pick_req(input logic up, input logic down, input logic tune);
        if (up)
            return REQ_UP;
        else if (down)
            return REQ_DOWN;
        else if (tune)
            return REQ_TUNE;
        return REQ_NONE;
    endfunction

endpackage

// File: rtl/pll_seq_timer.sv
// Wait timer: a loadable down-counter that reports when it has reached zero.
// A load of N-1 makes zero visible at the N-th edge after the load edge.
module pll_seq_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    // Count down toward zero; a load takes precedence over counting.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/pll_seq_tune.sv
// Retune word holder: captures the divider and post-divider words and
// builds the configuration and tuner words.
// Assumes DIV_W <= 31 so the change flag keeps bit 31 to itself.
module pll_seq_tune
    import pll_seq_pkg::*;
#(
    parameter int DIV_W     = 22,
    parameter int PDIV_W    = 3,
    parameter bit HAS_TUNER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tune_go,
    input  logic              chg_set,
    input  logic              chg_clr,
    input  logic [DIV_W-1:0]  tune_div,
    input  logic [PDIV_W-1:0] tune_pdiv,
    output logic [DIV_W-1:0]  div_word,
    output logic [PDIV_W-1:0] pdiv_word,
    output logic [CFG_W-1:0]  cfg_word,
    output logic [CFG_W-1:0]  tuner_word
);

    localparam int PAD_W = CFG_W - 1 - DIV_W;

    logic             chg_q;
    logic [CFG_W-1:0] cfg_at_load;

    // Configuration word as it will read right after this retune's load edge.
    assign cfg_at_load = {chg_set, {PAD_W{1'b0}}, tune_div};

    // Hold the divider words; they change only on an accepted retune.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_word  <= '0;
            pdiv_word <= '0;
        end else if (tune_go) begin
            div_word  <= tune_div;
            pdiv_word <= tune_pdiv;
        end
    end

    // Change flag: set at a running retune, cleared when its settle ends.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chg_q <= 1'b0;
        else if (chg_set)
            chg_q <= 1'b1;
        else if (chg_clr)
            chg_q <= 1'b0;
    end

    assign cfg_word = {chg_q, {PAD_W{1'b0}}, div_word};

    generate
        if (HAS_TUNER) begin : g_tuner
            logic [CFG_W-1:0] tuner_q;
            // Tuner word follows the configuration word plus one at each retune.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    tuner_q <= '0;
                else if (tune_go)
                    tuner_q <= cfg_at_load + 1'b1;
            end
            assign tuner_word = tuner_q;
        end else begin : g_no_tuner
            assign tuner_word = '0;
        end
    endgenerate

endmodule

// File: rtl/pll_seq_fsm.sv
// Sequencer state machine: orders the power, isolation, enable, tuner and
// reset-release steps and requests waits from the timer.
// Assumes PWR_CYC and SETTLE_CYC are at least 1 and fit in CNT_W bits.
module pll_seq_fsm
    import pll_seq_pkg::*;
#(
    parameter int EN_W       = 2,
    parameter bit HAS_RSTB   = 1'b1,
    parameter bit HAS_TUNER  = 1'b1,
    parameter int CNT_W      = 12,
    parameter int PWR_CYC    = 100,
    parameter int SETTLE_CYC = 2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_prep,
    input  logic             req_unprep,
    input  logic             req_tune,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             tune_go,
    output logic             chg_set,
    output logic             chg_clr,
    output logic             pwr_on,
    output logic             iso_en,
    output logic [EN_W-1:0]  pll_en,
    output logic             tuner_en,
    output logic             rst_bar,
    output logic             div_load,
    output logic             busy,
    output logic             done
);

    localparam logic [CNT_W-1:0] PWR_LD    = CNT_W'(PWR_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);

    seq_state_e      st_q, st_n;
    logic            pwr_n, iso_n, tun_n, rstb_n, done_n;
    logic [EN_W-1:0] en_n;
    req_kind_e       req;

    assign req = pick_req(req_prep, req_unprep, req_tune);

    // Next-state and next-output decode for every step of every sequence.
    always_comb begin
        st_n     = st_q;
        pwr_n    = pwr_on;
        iso_n    = iso_en;
        en_n     = pll_en;
        tun_n    = tuner_en;
        rstb_n   = rst_bar;
        done_n   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        tune_go  = 1'b0;
        chg_set  = 1'b0;
        chg_clr  = 1'b0;
        case (st_q)
            ST_IDLE: begin
                case (req)
                    REQ_UP: begin
                        pwr_n    = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = PWR_LD;
                        st_n     = ST_UP_W1;
                    end
                    REQ_DOWN: begin
                        if (HAS_RSTB) begin
                            rstb_n = 1'b0;
                            st_n   = ST_DN_TUN;
                        end else begin
                            tun_n = 1'b0;
                            st_n  = ST_DN_EN;
                        end
                    end
                    REQ_TUNE: begin
                        tune_go = 1'b1;
                        if (pll_en[0]) begin
                            chg_set  = 1'b1;
                            tmr_load = 1'b1;
                            tmr_val  = SETTLE_LD;
                            st_n     = ST_RT_W;
                        end else begin
                            done_n = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            ST_UP_W1: begin
                if (tmr_zero) begin
                    iso_n    = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = PWR_LD;
                    st_n     = ST_UP_W2;
                end
            end
            ST_UP_W2: begin
                if (tmr_zero) begin
                    en_n = '1;
                    st_n = ST_UP_TUN;
                end
            end
            ST_UP_TUN: begin
                tun_n    = HAS_TUNER;
                tmr_load = 1'b1;
                tmr_val  = SETTLE_LD;
                st_n     = ST_UP_W3;
            end
            ST_UP_W3: begin
                if (tmr_zero) begin
                    if (HAS_RSTB)
                        rstb_n = 1'b1;
                    done_n = 1'b1;
                    st_n   = ST_IDLE;
                end
            end
            ST_DN_TUN: begin
                tun_n = 1'b0;
                st_n  = ST_DN_EN;
            end
            ST_DN_EN: begin
                en_n = '0;
                st_n = ST_DN_ISO;
            end
            ST_DN_ISO: begin
                iso_n = 1'b1;
                st_n  = ST_DN_PWR;
            end
            ST_DN_PWR: begin
                pwr_n  = 1'b0;
                done_n = 1'b1;
                st_n   = ST_IDLE;
            end
            ST_RT_W: begin
                if (tmr_zero) begin
                    chg_clr = 1'b1;
                    done_n  = 1'b1;
                    st_n    = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // Register state and control outputs; reset leaves the PLL powered down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            pwr_on   <= 1'b0;
            iso_en   <= 1'b1;
            pll_en   <= '0;
            tuner_en <= 1'b0;
            rst_bar  <= 1'b0;
            done     <= 1'b0;
            div_load <= 1'b0;
        end else begin
            st_q     <= st_n;
            pwr_on   <= pwr_n;
            iso_en   <= iso_n;
            pll_en   <= en_n;
            tuner_en <= tun_n;
            rst_bar  <= rstb_n;
            done     <= done_n;
            div_load <= tune_go;
        end
    end

    assign busy = (st_q != ST_IDLE);

endmodule

// File: rtl/pll_seq_ctrl.sv
// Top of the PLL power and retune sequencer: ties the state machine, the
// wait timer and the retune word holder together.
// Assumes CLK_MHZ is the integer clock frequency in MHz.
module pll_seq_ctrl
    import pll_seq_pkg::*;
#(
    parameter int CLK_MHZ   = 100,
    parameter int PWR_US    = 1,
    parameter int SETTLE_US = 20,
    parameter int DIV_W     = 22,
    parameter int PDIV_W    = 3,
    parameter int EN_W      = 2,
    parameter bit HAS_RSTB  = 1'b1,
    parameter bit HAS_TUNER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_prep,
    input  logic              req_unprep,
    input  logic              req_tune,
    input  logic [DIV_W-1:0]  tune_div,
    input  logic [PDIV_W-1:0] tune_pdiv,
    output logic              pwr_on,
    output logic              iso_en,
    output logic [EN_W-1:0]   pll_en,
    output logic              tuner_en,
    output logic              rst_bar,
    output logic              div_load,
    output logic [DIV_W-1:0]  div_word,
    output logic [PDIV_W-1:0] pdiv_word,
    output logic [31:0]       cfg_word,
    output logic [31:0]       tuner_word,
    output logic              busy,
    output logic              done,
    output logic              prepared
);

    localparam int PWR_CYC    = CLK_MHZ * PWR_US;
    localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
    localparam int MAX_CYC    = (SETTLE_CYC > PWR_CYC) ? SETTLE_CYC : PWR_CYC;
    localparam int CNT_W      = $clog2(MAX_CYC + 1);

    logic             tmr_load, tmr_zero, tune_go, chg_set, chg_clr;
    logic [CNT_W-1:0] tmr_val;

    pll_seq_fsm #(
        .EN_W(EN_W), .HAS_RSTB(HAS_RSTB), .HAS_TUNER(HAS_TUNER),
        .CNT_W(CNT_W), .PWR_CYC(PWR_CYC), .SETTLE_CYC(SETTLE_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_prep(req_prep), .req_unprep(req_unprep), .req_tune(req_tune),
        .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .tune_go(tune_go), .chg_set(chg_set), .chg_clr(chg_clr),
        .pwr_on(pwr_on), .iso_en(iso_en), .pll_en(pll_en),
        .tuner_en(tuner_en), .rst_bar(rst_bar), .div_load(div_load),
        .busy(busy), .done(done)
    );

    pll_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    pll_seq_tune #(.DIV_W(DIV_W), .PDIV_W(PDIV_W), .HAS_TUNER(HAS_TUNER)) u_tune (
        .clk(clk), .rst_n(rst_n),
        .tune_go(tune_go), .chg_set(chg_set), .chg_clr(chg_clr),
        .tune_div(tune_div), .tune_pdiv(tune_pdiv),
        .div_word(div_word), .pdiv_word(pdiv_word),
        .cfg_word(cfg_word), .tuner_word(tuner_word)
    );

    assign prepared = pll_en[0];

endmodule

// File: rtl/pll_seq_ctrl_chk.sv
// Checker for the PLL sequencer: ordering and hold properties at the ports.
// Assumes it is attached to every pll_seq_ctrl instance by the bind below.
module pll_seq_ctrl_chk #(
    parameter int DIV_W     = 22,
    parameter int EN_W      = 2,
    parameter bit HAS_TUNER = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_on,
    input logic             iso_en,
    input logic [EN_W-1:0]  pll_en,
    input logic             rst_bar,
    input logic             div_load,
    input logic [DIV_W-1:0] div_word,
    input logic [31:0]      cfg_word,
    input logic [31:0]      tuner_word,
    input logic             busy,
    input logic             done
);

    // R2: isolation is released only while power is on
    a_r2_iso_needs_pwr: assert property (@(posedge clk) disable iff (!rst_n)
        !iso_en |-> pwr_on);

    // R2: enable bits are set only with isolation released
    a_r2_en_needs_iso_off: assert property (@(posedge clk) disable iff (!rst_n)
        (|pll_en) |-> !iso_en);

    // R3: reset release is only ever high while the PLL is enabled
    a_r3_rstb_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        rst_bar |-> pll_en[0]);

    // R4: power is off only while isolation is applied
    a_r4_off_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |-> iso_en);

    // R6: the change flag is raised only while the PLL is enabled
    a_r6_chg_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_word[31] |-> pll_en[0]);

    // R8: just after a load the tuner word is the configuration word plus one
    a_r8_tuner_word: assert property (@(posedge clk) disable iff (!rst_n)
        (div_load && HAS_TUNER) |-> (tuner_word == cfg_word + 32'd1));

    // R9: the divider word holds while a sequence is running
    a_r9_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(div_word));

    // R10: completion is reported only when no longer busy
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

bind pll_seq_ctrl pll_seq_ctrl_chk #(
    .DIV_W(DIV_W), .EN_W(EN_W), .HAS_TUNER(HAS_TUNER)
) u_chk (.*);

// File: tb/pll_seq_ctrl_bench.sv
// Bench: event-queue reference model of the sequencer, compared every cycle.
module pll_seq_ctrl_bench;

    localparam int CLK_MHZ = 3;
    localparam int C       = CLK_MHZ * 1;
    localparam int S       = CLK_MHZ * 20;
    localparam int DIV_W   = 22;
    localparam int PDIV_W  = 3;
    localparam int EN_W    = 2;

    localparam int A_PWR1 = 0, A_ISO0 = 1, A_EN1 = 2, A_TUN1 = 3, A_RST1 = 4;
    localparam int A_RST0 = 5, A_TUN0 = 6, A_EN0 = 7, A_ISO1 = 8, A_PWR0 = 9, A_CHG0 = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_prep = 1'b0, req_unprep = 1'b0, req_tune = 1'b0;
    logic [DIV_W-1:0]  tune_div = '0;
    logic [PDIV_W-1:0] tune_pdiv = '0;

    logic              pwr_on, iso_en, tuner_en, rst_bar, div_load, busy, done, prepared;
    logic [EN_W-1:0]   pll_en;
    logic [DIV_W-1:0]  div_word;
    logic [PDIV_W-1:0] pdiv_word;
    logic [31:0]       cfg_word, tuner_word;

    logic              b_pwr, b_iso, b_tun, b_rst, b_load, b_busy, b_done, b_prep;
    logic [EN_W-1:0]   b_en;
    logic [DIV_W-1:0]  b_div;
    logic [PDIV_W-1:0] b_pdiv;
    logic [31:0]       b_cfg, b_tw;

    always #5 clk = ~clk;

    pll_seq_ctrl #(.CLK_MHZ(CLK_MHZ), .DIV_W(DIV_W), .PDIV_W(PDIV_W), .EN_W(EN_W)) u_pll_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .req_prep(req_prep), .req_unprep(req_unprep),
        .req_tune(req_tune), .tune_div(tune_div), .tune_pdiv(tune_pdiv),
        .pwr_on(pwr_on), .iso_en(iso_en), .pll_en(pll_en), .tuner_en(tuner_en),
        .rst_bar(rst_bar), .div_load(div_load), .div_word(div_word),
        .pdiv_word(pdiv_word), .cfg_word(cfg_word), .tuner_word(tuner_word),
        .busy(busy), .done(done), .prepared(prepared));

    pll_seq_ctrl #(.CLK_MHZ(CLK_MHZ), .DIV_W(DIV_W), .PDIV_W(PDIV_W), .EN_W(EN_W),
                   .HAS_RSTB(1'b0)) u_pll_seq_ctrl_nr (
        .clk(clk), .rst_n(rst_n), .req_prep(req_prep), .req_unprep(req_unprep),
        .req_tune(req_tune), .tune_div(tune_div), .tune_pdiv(tune_pdiv),
        .pwr_on(b_pwr), .iso_en(b_iso), .pll_en(b_en), .tuner_en(b_tun),
        .rst_bar(b_rst), .div_load(b_load), .div_word(b_div),
        .pdiv_word(b_pdiv), .cfg_word(b_cfg), .tuner_word(b_tw),
        .busy(b_busy), .done(b_done), .prepared(b_prep));

    int    checks = 0, errors = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    // Reference model state
    int k = 0;
    int last_end = -1;
    int ev_t[$];
    int ev_a[$];
    logic              e_pwr = 0, e_iso = 1, e_tun = 0, e_rst = 0, e_chg = 0, e_load = 0;
    logic [EN_W-1:0]   e_en = '0;
    logic [DIV_W-1:0]  e_div = '0;
    logic [PDIV_W-1:0] e_pdiv = '0;
    logic [31:0]       e_tw = '0;
    logic              e_done = 0, e_busy = 0;
    int                done_cnt = 0;

    function automatic logic [31:0] mk_cfg(input logic chg, input logic [DIV_W-1:0] d);
        logic [31:0] w;
        w = 32'(d);
        w[31] = chg;
        return w;
    endfunction

    task automatic push_ev(input int t, input int a);
        ev_t.push_back(t);
        ev_a.push_back(a);
    endtask

    // Model update at each edge: accept requests, then fire events due now.
    always @(posedge clk) begin
        k = k + 1;
        e_load = 1'b0;
        if (!rst_n) begin
            e_pwr = 0; e_iso = 1; e_tun = 0; e_rst = 0; e_chg = 0; e_en = '0;
            e_div = '0; e_pdiv = '0; e_tw = '0;
            ev_t.delete(); ev_a.delete();
            last_end = -1;
        end else begin
            if (k > last_end) begin
                if (req_prep) begin
                    push_ev(k, A_PWR1);
                    push_ev(k + C, A_ISO0);
                    push_ev(k + 2*C, A_EN1);
                    push_ev(k + 2*C + 1, A_TUN1);
                    push_ev(k + 2*C + 1 + S, A_RST1);
                    last_end = k + 2*C + 1 + S;
                end else if (req_unprep) begin
                    push_ev(k, A_RST0);
                    push_ev(k + 1, A_TUN0);
                    push_ev(k + 2, A_EN0);
                    push_ev(k + 3, A_ISO1);
                    push_ev(k + 4, A_PWR0);
                    last_end = k + 4;
                end else if (req_tune) begin
                    e_div = tune_div;
                    e_pdiv = tune_pdiv;
                    e_load = 1'b1;
                    if (e_en[0]) begin
                        e_chg = 1'b1;
                        push_ev(k + S, A_CHG0);
                        last_end = k + S;
                    end else begin
                        last_end = k;
                    end
                    e_tw = mk_cfg(e_chg, e_div) + 32'd1;
                end
            end
            for (int i = ev_t.size() - 1; i >= 0; i--) begin
                if (ev_t[i] == k) begin
                    case (ev_a[i])
                        A_PWR1: e_pwr = 1;
                        A_ISO0: e_iso = 0;
                        A_EN1:  e_en = '1;
                        A_TUN1: e_tun = 1;
                        A_RST1: e_rst = 1;
                        A_RST0: e_rst = 0;
                        A_TUN0: e_tun = 0;
                        A_EN0:  e_en = '0;
                        A_ISO1: e_iso = 1;
                        A_PWR0: e_pwr = 0;
                        A_CHG0: e_chg = 0;
                        default: ;
                    endcase
                    ev_t.delete(i);
                    ev_a.delete(i);
                end
            end
        end
        e_done = rst_n && (k == last_end);
        e_busy = rst_n && (last_end > k);
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h (edge %0d)", req, what, act, exp, k);
        end
    endtask

    // Compare every output against the model away from the clock edge.
    always @(negedge clk) begin
        if (k >= 1 && !finished) begin
            if (done) done_cnt++;
            chk(cur_req, "pwr_on",     32'(pwr_on),     32'(e_pwr));
            chk(cur_req, "iso_en",     32'(iso_en),     32'(e_iso));
            chk(cur_req, "pll_en",     32'(pll_en),     32'(e_en));
            chk(cur_req, "tuner_en",   32'(tuner_en),   32'(e_tun));
            chk(cur_req, "rst_bar",    32'(rst_bar),    32'(e_rst));
            chk(cur_req, "prepared",   32'(prepared),   32'(e_en[0]));
            chk(cur_req, "div_load",   32'(div_load),   32'(e_load));
            chk(cur_req, "div_word",   32'(div_word),   32'(e_div));
            chk(cur_req, "pdiv_word",  32'(pdiv_word),  32'(e_pdiv));
            chk(cur_req, "cfg_word",   cfg_word,        mk_cfg(e_chg, e_div));
            chk(cur_req, "tuner_word", tuner_word,      e_tw);
            chk(cur_req, "busy",       32'(busy),       32'(e_busy));
            chk(cur_req, "done",       32'(done),       32'(e_done));
            chk("R3", "nr_rst_bar",    32'(b_rst),      32'd0);
        end
    end

    task automatic pulse(input logic p, input logic u, input logic t,
                         input logic [DIV_W-1:0] d, input logic [PDIV_W-1:0] pd);
        @(negedge clk);
        req_prep = p; req_unprep = u; req_tune = t; tune_div = d; tune_pdiv = pd;
        @(negedge clk);
        req_prep = 0; req_unprep = 0; req_tune = 0;
    endtask

    task automatic wait_idle();
        while (last_end >= k) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        chk("R1", "reset iso_en", 32'(iso_en), 32'd1);
        chk("R1", "reset pwr_on", 32'(pwr_on), 32'd0);
        chk("R1", "reset busy",   32'(busy),   32'd0);

        // Retune while off: words only, no flag, no wait.
        cur_req = "R7";
        pulse(0, 0, 1, 22'h12345, 3'd2);
        chk("R7", "off-retune busy", 32'(busy), 32'd0);
        wait_idle();
        chk("R8", "cfg layout off", cfg_word, 32'h0001_2345);
        chk("R8", "tuner word off", tuner_word, 32'h0001_2346);

        // Bring-up, with dropped requests part way through.
        cur_req = "R2";
        done_cnt = 0;
        pulse(1, 0, 0, '0, '0);
        repeat (4) @(negedge clk);
        cur_req = "R9";
        pulse(0, 1, 1, 22'h3ffff, 3'd5);
        chk("R9", "div held while busy", 32'(div_word), 32'h12345);
        cur_req = "R3";
        wait_idle();
        chk("R3", "rst_bar after settle", 32'(rst_bar), 32'd1);
        chk("R3", "no-rstb variant tuner_en", 32'(b_tun), 32'd1);
        chk("R5", "prepared", 32'(prepared), 32'd1);
        chk("R10", "one done pulse", 32'(done_cnt), 32'd1);

        // Retune while running: flag, settle wait, tuner word.
        cur_req = "R6";
        pulse(0, 0, 1, 22'h2abcd, 3'd3);
        chk("R6", "change flag set", 32'(cfg_word[31]), 32'd1);
        chk("R8", "tuner word on", tuner_word, 32'h8002_abce);
        wait_idle();
        chk("R6", "change flag cleared", 32'(cfg_word[31]), 32'd0);

        // Coincident unprepare and retune: unprepare wins.
        cur_req = "R9";
        pulse(0, 1, 1, 22'h00777, 3'd1);
        cur_req = "R4";
        wait_idle();
        chk("R4", "prepared after down", 32'(prepared), 32'd0);
        chk("R9", "retune lost to unprepare", 32'(div_word), 32'h2abcd);

        // All three at once: prepare wins.
        cur_req = "R9";
        pulse(1, 1, 1, 22'h00555, 3'd4);
        cur_req = "R2";
        wait_idle();
        chk("R9", "prepare won", 32'(prepared), 32'd1);

        cur_req = "R4";
        pulse(0, 1, 0, '0, '0);
        wait_idle();
        chk("R4", "iso after down", 32'(iso_en), 32'd1);
        finish_run();
    end

endmodule